// File: doc/BRIEF.md
# GPIO Interrupt Cause Controller

This block is the interrupt front end for a bank of 32 general-purpose input lines. Each line is synchronised to the core clock and XORed with a per-line inversion bit. The result is the line's corrected value. It is read back through the register interface and feeds two cause paths.

The level path passes the corrected value straight through a level enable and holds nothing. The edge path records every 0-to-1 transition of the corrected value in a sticky cause register. Software acknowledges a recorded edge by writing a zero to its bit. Because the inversion bit sits ahead of both paths, software can catch both edges of a line by flipping that bit after each event.

Only lines that the pin-direction configuration marks as inputs may contribute. The qualified causes of each group of eight lines are ORed into one registered group request toward the main interrupt controller.

Top module: `gpio_cause_ctrl`

## Requirements
- R1: A read of word address 0x110 returns, for each line, the synchronised pin value XOR that line's inversion bit. Writes to 0x110 have no effect.
- R2: The inversion register at 0x10C is read/write and resets to zero. A 0 bit selects active-high or rising detection, and a 1 bit selects active-low or falling detection.
- R3: A level-enabled line (level enable register at 0x11C, bit set) drives its group request while its corrected value is 1. The request drops once the corrected value returns to 0; nothing is latched. The request rises 3 clock edges after the pin changes.
- R4: A 0-to-1 change of a line's corrected value sets that line's bit in the edge cause register at 0x114. The bit stays set after the pin falls. With the edge enable set, the group request rises 4 clock edges after the pin changes.
- R5: The edge cause reaches the group request only through the edge enable register at 0x118. The corrected value reaches it only through the level enable. Clearing an enable does not clear the recorded cause.
- R6: A write to 0x114 clears every cause bit written as 0 and keeps every bit written as 1.
- R7: If a new edge and a software clear hit the same cause bit in the same cycle, the bit ends up set.
- R8: Lines 8g to 8g+7 drive only bit g of the group request output (g = 0..3).
- R9: A line whose direction bit is 0 contributes nothing to the group request, whatever its enables and cause.
- R10: After reset, the inversion, edge enable, level enable and edge cause registers read zero, and all group requests are low.
- R11: A read of any word address other than the five above returns zero. A write to such an address changes nothing.
- R12: Inverting a line's inversion bit while its pin is held low records exactly one edge. Returning the bit to 0 records none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | 32 | Asynchronous pin levels |
| pin_is_input_i | input | 32 | Per-line direction qualifier, 1 = input |
| reg_addr_i | input | 12 | Register byte address |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered from the address one cycle earlier |
| group_irq_o | output | 4 | Registered per-group interrupt requests |

## Verification
A pin change passes two synchroniser flops before the corrected value moves. The level path then reaches `group_irq_o` on the third clock edge after the pin is driven. The edge path adds the cause register, so its request lands on the fourth edge. Register writes take effect at the edge that samples the strobe, and read data appears one edge after the address is presented.

The bench drives every input on a falling edge and samples on a later falling edge. The latency tests check that the output is still low one falling edge before the due edge and high on it. The set-versus-clear collision places the clearing write on exactly the third edge after the pin rise.

// File: rtl/gpio_cause_pkg.sv
package gpio_cause_pkg;

  localparam int unsigned REG_ADDR_W = 12;

  // Word addresses of the register map
  localparam logic [REG_ADDR_W-1:0] ADDR_INVERT = 12'h10C;
  localparam logic [REG_ADDR_W-1:0] ADDR_VALUE  = 12'h110;
  localparam logic [REG_ADDR_W-1:0] ADDR_ECAUSE = 12'h114;
  localparam logic [REG_ADDR_W-1:0] ADDR_EEN    = 12'h118;
  localparam logic [REG_ADDR_W-1:0] ADDR_LEN    = 12'h11C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_INVERT,
    SEL_VALUE,
    SEL_ECAUSE,
    SEL_EEN,
    SEL_LEN
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [REG_ADDR_W-1:0] addr);
    reg_sel_e sel;
    case (addr)
      ADDR_INVERT: sel = SEL_INVERT;
      ADDR_VALUE:  sel = SEL_VALUE;
      ADDR_ECAUSE: sel = SEL_ECAUSE;
      ADDR_EEN:    sel = SEL_EEN;
      ADDR_LEN:    sel = SEL_LEN;
      default:     sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] value_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] keep_i,
  output logic [WIDTH-1:0] cause_o
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] cause_q;
  logic [WIDTH-1:0] rise;
  logic [WIDTH-1:0] kept;

  assign rise = value_i & ~prev_q;
  assign kept = clr_en_i ? (cause_q & keep_i) : cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= value_i;
      // a new rise takes precedence over a clear in the same cycle
      cause_q <= kept | rise;
    end
  end

  assign cause_o = cause_q;

endmodule

// File: rtl/gpio_cause_regs.sv
module gpio_cause_regs
  import gpio_cause_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  wr_i,
  input  logic [WIDTH-1:0]      wdata_i,
  input  logic [WIDTH-1:0]      value_i,
  input  logic [WIDTH-1:0]      ecause_i,
  output logic [WIDTH-1:0]      invert_o,
  output logic [WIDTH-1:0]      een_o,
  output logic [WIDTH-1:0]      len_o,
  output logic                  ecause_wr_o,
  output logic [WIDTH-1:0]      rdata_o
);

  reg_sel_e         sel;
  logic [WIDTH-1:0] invert_q;
  logic [WIDTH-1:0] een_q;
  logic [WIDTH-1:0] len_q;
  logic [WIDTH-1:0] rdata_q;
  logic [WIDTH-1:0] rd_mux;

  assign sel = decode_addr(addr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      invert_q <= '0;
      een_q    <= '0;
      len_q    <= '0;
    end else if (wr_i) begin
      case (sel)
        SEL_INVERT: invert_q <= wdata_i;
        SEL_EEN:    een_q    <= wdata_i;
        SEL_LEN:    len_q    <= wdata_i;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_INVERT: rd_mux = invert_q;
      SEL_VALUE:  rd_mux = value_i;
      SEL_ECAUSE: rd_mux = ecause_i;
      SEL_EEN:    rd_mux = een_q;
      SEL_LEN:    rd_mux = len_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign invert_o    = invert_q;
  assign een_o       = een_q;
  assign len_o       = len_q;
  assign ecause_wr_o = wr_i && (sel == SEL_ECAUSE);
  assign rdata_o     = rdata_q;

endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned GROUP_LINES = 8,
  localparam int unsigned GROUPS     = WIDTH / GROUP_LINES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  cause_i,
  output logic [GROUPS-1:0] irq_o
);

  logic [GROUPS-1:0] irq_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) irq_q[g] <= 1'b0;
      else     irq_q[g] <= |cause_i[g*GROUP_LINES +: GROUP_LINES];
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/gpio_cause_ctrl.sv
module gpio_cause_ctrl
  import gpio_cause_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned GROUP_LINES = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_GROUPS = NUM_LINES / GROUP_LINES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LINES-1:0]  pin_i,
  input  logic [NUM_LINES-1:0]  pin_is_input_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic [NUM_LINES-1:0]  reg_wdata_i,
  output logic [NUM_LINES-1:0]  reg_rdata_o,
  output logic [NUM_GROUPS-1:0] group_irq_o
);

  logic [NUM_LINES-1:0] pin_sync;
  logic [NUM_LINES-1:0] invert;
  logic [NUM_LINES-1:0] line_value;
  logic [NUM_LINES-1:0] edge_cause;
  logic [NUM_LINES-1:0] edge_en;
  logic [NUM_LINES-1:0] level_en;
  logic [NUM_LINES-1:0] line_cause;
  logic                 ecause_wr;

  gpio_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  assign line_value = pin_sync ^ invert;

  gpio_cause_regs #(
    .WIDTH (NUM_LINES)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (reg_addr_i),
    .wr_i        (reg_wr_i),
    .wdata_i     (reg_wdata_i),
    .value_i     (line_value),
    .ecause_i    (edge_cause),
    .invert_o    (invert),
    .een_o       (edge_en),
    .len_o       (level_en),
    .ecause_wr_o (ecause_wr),
    .rdata_o     (reg_rdata_o)
  );

  gpio_edge_latch #(
    .WIDTH (NUM_LINES)
  ) u_edge (
    .clk      (clk),
    .rst      (rst),
    .value_i  (line_value),
    .clr_en_i (ecause_wr),
    .keep_i   (reg_wdata_i),
    .cause_o  (edge_cause)
  );

  assign line_cause = ((line_value & level_en) | (edge_cause & edge_en)) & pin_is_input_i;

  gpio_group_or #(
    .WIDTH       (NUM_LINES),
    .GROUP_LINES (GROUP_LINES)
  ) u_group (
    .clk     (clk),
    .rst     (rst),
    .cause_i (line_cause),
    .irq_o   (group_irq_o)
  );

endmodule

// File: rtl/gpio_cause_chk.sv
module gpio_cause_chk
  import gpio_cause_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_LINES-1:0]  pin_is_input_i,
  input logic [REG_ADDR_W-1:0] reg_addr_i,
  input logic                  reg_wr_i,
  input logic [NUM_LINES-1:0]  reg_rdata_o,
  input logic [NUM_GROUPS-1:0] group_irq_o,
  input logic [NUM_LINES-1:0]  ecause,
  input logic [NUM_LINES-1:0]  een,
  input logic [NUM_LINES-1:0]  len
);

  logic cause_written;
  logic addr_mapped;

  assign cause_written = reg_wr_i && (reg_addr_i == ADDR_ECAUSE);
  assign addr_mapped   = (decode_addr(reg_addr_i) != SEL_NONE);

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (group_irq_o == '0 && ecause == '0));

  // R4
  sticky_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !cause_written |=> ((ecause & $past(ecause)) == $past(ecause)));

  // R9
  dir_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_is_input_i == '0) |=> (group_irq_o == '0));

  // R5
  enables_off_chk: assert property (@(posedge clk) disable iff (rst)
    (een == '0 && len == '0) |=> (group_irq_o == '0));

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_mapped |=> (reg_rdata_o == '0));

endmodule

bind gpio_cause_ctrl gpio_cause_chk #(
  .NUM_LINES  (NUM_LINES),
  .NUM_GROUPS (NUM_GROUPS)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .pin_is_input_i (pin_is_input_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wr_i       (reg_wr_i),
  .reg_rdata_o    (reg_rdata_o),
  .group_irq_o    (group_irq_o),
  .ecause         (edge_cause),
  .een            (edge_en),
  .len            (level_en)
);

// File: tb/tb_gpio_cause_ctrl.sv
module tb_gpio_cause_ctrl;

  localparam logic [11:0] A_INV = 12'h10C;
  localparam logic [11:0] A_VAL = 12'h110;
  localparam logic [11:0] A_EC  = 12'h114;
  localparam logic [11:0] A_EEN = 12'h118;
  localparam logic [11:0] A_LEN = 12'h11C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_is_input_i = '1;
  logic [11:0] reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [3:0]  group_irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_cause_ctrl dut (
    .clk            (clk),
    .rst            (rst),
    .pin_i          (pin_i),
    .pin_is_input_i (pin_is_input_i),
    .reg_addr_i     (reg_addr_i),
    .reg_wr_i       (reg_wr_i),
    .reg_wdata_i    (reg_wdata_i),
    .reg_rdata_o    (reg_rdata_o),
    .group_irq_o    (group_irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr_i  = a;
    reg_wdata_i = d;
    reg_wr_i    = 1'b1;
    @(negedge clk);
    reg_wr_i    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr_i = a;
    @(negedge clk);
    d = reg_rdata_o;
  endtask

  task automatic quiesce();
    pin_i = '0;
    pin_is_input_i = '1;
    wr(A_INV, '0);
    wr(A_EEN, '0);
    wr(A_LEN, '0);
    idle(5);
    wr(A_EC, '0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R10 group after reset", {28'd0, group_irq_o}, 32'd0);
    rd(A_INV, v); check("R10 invert reset", v, 32'd0);
    rd(A_EC,  v); check("R10 edge cause reset", v, 32'd0);
    rd(A_EEN, v); check("R10 edge enable reset", v, 32'd0);
    rd(A_LEN, v); check("R10 level enable reset", v, 32'd0);
  endtask

  task automatic t_value();
    logic [31:0] v;
    quiesce();
    pin_i = 32'h12345678;
    wr(A_INV, 32'h0000FF00);
    idle(4);
    rd(A_INV, v); check("R2 invert readback", v, 32'h0000FF00);
    rd(A_VAL, v); check("R1 corrected value", v, 32'h1234A978);
    wr(A_VAL, 32'hFFFFFFFF);
    rd(A_VAL, v); check("R1 value write ignored", v, 32'h1234A978);
  endtask

  task automatic t_level();
    quiesce();
    wr(A_LEN, 32'h0000_0008);
    idle(4);
    check("R3 idle low", {28'd0, group_irq_o}, 32'd0);
    pin_i[3] = 1'b1;
    idle(2);
    check("R3 not before third edge", {28'd0, group_irq_o}, 32'd0);
    idle(1);
    check("R3 level on third edge", {28'd0, group_irq_o}, 32'd1);
    pin_i[3] = 1'b0;
    idle(4);
    check("R3 level not latched", {28'd0, group_irq_o}, 32'd0);
    wr(A_INV, 32'h0010_0000);
    wr(A_LEN, 32'h0010_0000);
    idle(4);
    check("R2 active-low level", {28'd0, group_irq_o}, 32'h4);
    pin_i[20] = 1'b1;
    idle(4);
    check("R2 active-low released", {28'd0, group_irq_o}, 32'd0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    quiesce();
    wr(A_EEN, 32'h4000_0200);
    idle(2);
    pin_i[9] = 1'b1;
    idle(3);
    check("R4 not before fourth edge", {28'd0, group_irq_o}, 32'd0);
    idle(1);
    check("R4 edge on fourth edge", {28'd0, group_irq_o}, 32'h2);
    pin_i[9] = 1'b0;
    idle(5);
    check("R4 sticky after pin falls", {28'd0, group_irq_o}, 32'h2);
    rd(A_EC, v); check("R4 cause readback", v, 32'h0000_0200);
    pin_i[30] = 1'b1;
    idle(2);
    pin_i[30] = 1'b0;
    idle(4);
    wr(A_EEN, 32'h4000_0000);
    idle(2);
    check("R5 masked edge hidden", {28'd0, group_irq_o}, 32'h8);
    rd(A_EC, v); check("R5 masking keeps cause", v, 32'h4000_0200);
    wr(A_EC, ~32'h4000_0000);
    idle(2);
    rd(A_EC, v); check("R6 write-zero clears, write-one keeps", v, 32'h0000_0200);
    check("R6 group drops after ack", {28'd0, group_irq_o}, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pin_i[12] = 1'b1;
    idle(2);
    wr(A_EC, 32'd0);
    rd(A_EC, v); check("R7 set wins over clear", v, 32'h0000_1000);
    pin_i[12] = 1'b0;
  endtask

  task automatic t_dir();
    quiesce();
    pin_is_input_i = ~32'h20;
    wr(A_LEN, 32'h20);
    wr(A_EEN, 32'h20);
    pin_i[5] = 1'b1;
    idle(6);
    check("R9 non-input line silent", {28'd0, group_irq_o}, 32'd0);
    pin_is_input_i = '1;
    idle(2);
    check("R9 input line asserts", {28'd0, group_irq_o}, 32'd1);
  endtask

  task automatic t_groups();
    quiesce();
    wr(A_LEN, '1);
    for (int g = 0; g < 4; g++) begin
      pin_i = 32'd1 << (g * 8 + 7 - g);
      idle(4);
      check($sformatf("R8 group %0d", g), {28'd0, group_irq_o}, 32'd1 << g);
    end
  endtask

  task automatic t_flip();
    logic [31:0] v;
    quiesce();
    wr(A_INV, 32'h0002_0000);
    idle(3);
    rd(A_EC, v); check("R12 flip records one edge", v, 32'h0002_0000);
    wr(A_EC, 32'd0);
    wr(A_INV, 32'd0);
    idle(3);
    rd(A_EC, v); check("R12 flip back records none", v, 32'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(12'h120, 32'hFFFF_FFFF);
    rd(12'h120, v); check("R11 unmapped read zero", v, 32'd0);
    rd(12'h000, v); check("R11 low address zero", v, 32'd0);
    rd(A_INV, v);   check("R11 unmapped write harmless", v, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_value();
    t_level();
    t_edge();
    t_collide();
    t_dir();
    t_groups();
    t_flip();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule